// File: doc/BRIEF.md
# Two-Step Converter Conversion Sequencer

This block is the digital control core of an 8-bit two-step (half-flash) analog-to-digital converter with an input multiplexer. Two external comparator banks each present a 15-line thermometer code. The coarse bank resolves the upper nibble and the fine bank, working on the residue, resolves the lower nibble. The sequencer starts a conversion when both chip-select and read are low. It latches the channel address and holds a track phase for a set number of clocks. It then latches the coarse nibble into the result register, runs the fine phase, and latches the fine nibble at end of conversion, which it signals on an active-low interrupt.

Two read styles share the same strobes. In a wait-state read, no earlier result is pending and the strobes are held low through the conversion. The data bus stays released until end of conversion and then drives the new word, and the open-drain ready output is released at that moment. In a pipelined read, a completed result has not yet been read out. The read drives that result at once, starts the next conversion, and is normally released before the conversion ends. Both strobes pass through two-flop synchronizers before any edge is detected, so every strobe response lags the pin by the synchronizer delay.

Top module: `hfadc_seq`

## Requirements
- R1: During and right after reset, data_oe is 0, int_n is 1, rdy_pull is 0 and mux_sel is 0.
- R2: A conversion starts on the clock where both synchronized strobes are first seen low together. mux_sel takes the value of addr at that moment, visible 3 clocks after the strobe change. Later changes of addr do not alter mux_sel.
- R3: The result word has the upper nibble (bits 7:4) equal to the number of ones in the coarse code and the lower nibble (bits 3:0) equal to the number of ones in the fine code. A code with bubbles is counted the same way, so each nibble is at most 15.
- R4: The coarse code is sampled TRACK_CYC clocks after the start. The fine code is sampled FINE_CYC clocks later, when int_n falls. int_n is first low TRACK_CYC+FINE_CYC+3 clocks after the strobe change.
- R5: With no pending result, a read keeps data_oe at 0. If the strobes are still low at end of conversion, data_oe becomes 1 with the new word and rdy_pull returns to 0 in the same clock as int_n falls.
- R6: A conversion that ends with the strobes not both low leaves its result pending. The next read sets data_oe to 1, 3 clocks after the strobe change, driving that pending word, and also starts a new conversion.
- R7: int_n returns to 1 three clocks after the first of chip-select or read rises, and stays low for the whole of a read that begins while it is low.
- R8: rdy_pull (1 = pull ready low) becomes 1 three clocks after chip-select falls. It returns to 0 three clocks after chip-select rises, or at end of conversion while both strobes are low.
- R9: A start request during a conversion is ignored: mux_sel keeps its value and end of conversion occurs at the original time.
- R10: data_oe returns to 0 three clocks after the first of chip-select or read rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip-select strobe, active low, asynchronous |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| addr | input | ADDR_W | Channel address, latched at start |
| coarse_therm | input | 15 | Thermometer code from the coarse comparator bank |
| fine_therm | input | 15 | Thermometer code from the fine comparator bank |
| mux_sel | output | ADDR_W | Latched channel select for the input multiplexer |
| data_out | output | 8 | Result register, valid on the bus while data_oe is 1 |
| data_oe | output | 1 | Tri-state enable for the data bus |
| int_n | output | 1 | End-of-conversion interrupt, active low |
| rdy_pull | output | 1 | 1 = open-drain ready output pulls low, 0 = released |

## Verification
The properties assume that each strobe level lasts several clocks, so the synchronized copies settle cleanly. They also assume that a strobe release never lands on the same clock as end of conversion, because the two would then compete for int_n and the ready output. The stimulus holds every strobe level for at least three clocks and places releases well away from the end-of-conversion clock. Comparator codes and the address are held steady around their sampling clocks. Pipelined reads are released before the coarse latch, so the word on the bus does not change during the read.

// File: rtl/hfadc_pkg.sv
package hfadc_pkg;

    localparam int THERM_W = 15;
    localparam int NIB_W   = $clog2(THERM_W + 1);
    localparam int DATA_W  = 2 * NIB_W;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRACK = 2'd1,
        ST_FINE  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] lo;
    } conv_word_t;

    // population count of a thermometer code; bubbles are absorbed
    function automatic logic [NIB_W-1:0] therm_ones(input logic [THERM_W-1:0] t);
        logic [NIB_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < THERM_W; i++) begin
            acc = acc + NIB_W'(t[i]);
        end
        return acc;
    endfunction

endpackage

// File: rtl/hfadc_sync.sv
module hfadc_sync #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // per-bit two-stage synchronizer, idle level high
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta;
        logic stable;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta   <= 1'b1;
                stable <= 1'b1;
            end else begin
                meta   <= d[g];
                stable <= meta;
            end
        end
        assign q[g] = stable;
    end
endmodule

// File: rtl/hfadc_therm_enc.sv
module hfadc_therm_enc
    import hfadc_pkg::*;
(
    input  logic [THERM_W-1:0] therm,
    output logic [NIB_W-1:0]   nib
);
    always_comb begin
        nib = therm_ones(therm);
    end
endmodule

// File: rtl/hfadc_ctrl.sv
module hfadc_ctrl
    import hfadc_pkg::*;
#(
    parameter int TRACK_CYC = 250,
    parameter int FINE_CYC  = 150,
    parameter int ADDR_W    = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_s,
    input  logic              rd_s,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NIB_W-1:0]  coarse_nib,
    input  logic [NIB_W-1:0]  fine_nib,
    output logic [ADDR_W-1:0] mux_sel,
    output conv_word_t        word,
    output logic              data_oe,
    output logic              int_n,
    output logic              rdy_pull,
    output seq_state_t        state
);
    localparam int CNT_MAX = (TRACK_CYC > FINE_CYC) ? TRACK_CYC : FINE_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    logic [CNT_W-1:0] cnt;
    logic             sel_q;
    logic             cs_q;
    logic             pending;

    logic sel, start, sel_end, cs_fall, cs_rise, eoc, phase_done;

    always_comb begin
        sel        = !cs_s && !rd_s;
        phase_done = (cnt == '0);
        start      = sel && !sel_q && (state == ST_IDLE);
        sel_end    = sel_q && !sel;
        cs_fall    = cs_q && !cs_s;
        cs_rise    = !cs_q && cs_s;
        eoc        = (state == ST_FINE) && phase_done;
    end

    // conversion phases
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            mux_sel <= '0;
            word    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        state   <= ST_TRACK;
                        cnt     <= CNT_W'(TRACK_CYC - 1);
                        mux_sel <= addr;
                    end
                end
                ST_TRACK: begin
                    if (phase_done) begin
                        word.hi <= coarse_nib;
                        state   <= ST_FINE;
                        cnt     <= CNT_W'(FINE_CYC - 1);
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                ST_FINE: begin
                    if (phase_done) begin
                        word.lo <= fine_nib;
                        state   <= ST_IDLE;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // strobe bookkeeping, bus enable, interrupt and ready
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q    <= 1'b0;
            cs_q     <= 1'b1;
            pending  <= 1'b0;
            data_oe  <= 1'b0;
            int_n    <= 1'b1;
            rdy_pull <= 1'b0;
        end else begin
            sel_q <= sel;
            cs_q  <= cs_s;

            if (start)
                pending <= 1'b0;
            else if (eoc && !sel)
                pending <= 1'b1;

            if (!sel)
                data_oe <= 1'b0;
            else if (start && pending)
                data_oe <= 1'b1;
            else if (eoc)
                data_oe <= 1'b1;

            if (eoc)
                int_n <= 1'b0;
            else if (sel_end)
                int_n <= 1'b1;

            if (cs_fall)
                rdy_pull <= 1'b1;
            else if (cs_rise)
                rdy_pull <= 1'b0;
            else if (eoc && sel)
                rdy_pull <= 1'b0;
        end
    end
endmodule

// File: rtl/hfadc_seq.sv
module hfadc_seq
    import hfadc_pkg::*;
#(
    parameter int TRACK_CYC = 250,
    parameter int FINE_CYC  = 150,
    parameter int ADDR_W    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_n,
    input  logic               rd_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [THERM_W-1:0] coarse_therm,
    input  logic [THERM_W-1:0] fine_therm,
    output logic [ADDR_W-1:0]  mux_sel,
    output logic [DATA_W-1:0]  data_out,
    output logic               data_oe,
    output logic               int_n,
    output logic               rdy_pull
);
    localparam int N_STAGE = 2;

    logic                            cs_s;
    logic                            rd_s;
    logic [N_STAGE-1:0][THERM_W-1:0] therm_in;
    logic [N_STAGE-1:0][NIB_W-1:0]   nib;
    conv_word_t                      word;
    seq_state_t                      state;

    hfadc_sync #(.W(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, rd_n}),
        .q   ({cs_s, rd_s})
    );

    assign therm_in[0] = coarse_therm;
    assign therm_in[1] = fine_therm;

    for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
        hfadc_therm_enc u_enc (
            .therm (therm_in[s]),
            .nib   (nib[s])
        );
    end

    hfadc_ctrl #(
        .TRACK_CYC (TRACK_CYC),
        .FINE_CYC  (FINE_CYC),
        .ADDR_W    (ADDR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cs_s       (cs_s),
        .rd_s       (rd_s),
        .addr       (addr),
        .coarse_nib (nib[0]),
        .fine_nib   (nib[1]),
        .mux_sel    (mux_sel),
        .word       (word),
        .data_oe    (data_oe),
        .int_n      (int_n),
        .rdy_pull   (rdy_pull),
        .state      (state)
    );

    assign data_out = word;
endmodule

// File: rtl/hfadc_seq_chk.sv
module hfadc_seq_chk
    import hfadc_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cs_s,
    input logic              rd_s,
    input seq_state_t        state,
    input logic [ADDR_W-1:0] mux_sel,
    input logic              data_oe,
    input logic              int_n,
    input logic              rdy_pull
);
    AST_START_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_IDLE && state == ST_TRACK) |-> $past(!cs_s && !rd_s)); // R2

    AST_INT_FALL_AT_END: assert property (@(posedge clk) disable iff (rst)
        $fell(int_n) |-> ($past(state) == ST_FINE)); // R4

    AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> $past(!cs_s && !rd_s)); // R10

    AST_RDY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy_pull) |-> ($past(cs_s) || $past(state) == ST_FINE)); // R8

    AST_MUX_HELD_BUSY: assert property (@(posedge clk) disable iff (rst)
        ($past(state) != ST_IDLE) |-> $stable(mux_sel)); // R9
endmodule

bind hfadc_seq hfadc_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs_s     (cs_s),
    .rd_s     (rd_s),
    .state    (state),
    .mux_sel  (mux_sel),
    .data_oe  (data_oe),
    .int_n    (int_n),
    .rdy_pull (rdy_pull)
);

// File: tb/hfadc_seq_test.sv
`timescale 1ns/1ps
module hfadc_seq_test;
    localparam int TT = 20;
    localparam int TF = 12;
    localparam int EOC = TT + TF + 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        rd_n = 1'b1;
    logic [2:0]  addr = '0;
    logic [14:0] coarse_therm = '0;
    logic [14:0] fine_therm = '0;
    logic [2:0]  mux_sel;
    logic [7:0]  data_out;
    logic        data_oe;
    logic        int_n;
    logic        rdy_pull;

    int n_checks = 0;
    int n_errors = 0;
    int pos = 0;
    bit done = 0;
    bit oe_q = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    hfadc_seq #(.TRACK_CYC(TT), .FINE_CYC(TF), .ADDR_W(3)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .coarse_therm(coarse_therm), .fine_therm(fine_therm),
        .mux_sel(mux_sel), .data_out(data_out), .data_oe(data_oe),
        .int_n(int_n), .rdy_pull(rdy_pull)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_to(input int p);
        while (pos < p) begin
            @(negedge clk);
            pos++;
        end
    endtask

    task automatic strobe(input bit c, input bit r);
        cs_n = c;
        rd_n = r;
    endtask

    // scoreboard monitor: each new bus drive must match the queue head
    always @(negedge clk) begin
        if (!rst && data_oe && !oe_q) begin
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected bus drive", int'(data_out), 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(data_out == e, "R3 R6 bus word", int'(data_out), int'(e));
            end
        end
        oe_q = data_oe;
    end

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        finish_run();
    end

    initial begin
        int p;
        repeat (4) @(negedge clk);
        check(data_oe == 0, "R1 data_oe", data_oe, 0);
        check(int_n == 1, "R1 int_n", int_n, 1);
        check(rdy_pull == 0, "R1 rdy_pull", rdy_pull, 0);
        check(mux_sel == 0, "R1 mux_sel", mux_sel, 0);
        rst = 0;
        @(negedge clk);
        check(data_oe == 0 && int_n == 1 && rdy_pull == 0, "R1 after reset", {data_oe, int_n, rdy_pull}, 3'b010);
        repeat (3) @(negedge clk);

        // wait-state read: 9 coarse ones, 3 fine ones -> 0x93
        exp_q.push_back(8'h93);
        addr = 3'd5; coarse_therm = 15'h01FF; fine_therm = 15'h0007;
        strobe(0, 0); pos = 0;
        go_to(3);
        check(mux_sel == 5, "R2 address latched", mux_sel, 5);
        check(rdy_pull == 1, "R8 ready pulled", rdy_pull, 1);
        check(data_oe == 0, "R5 bus released", data_oe, 0);
        go_to(4); addr = 3'd2;
        go_to(3 + TT); coarse_therm = 15'h0000;
        go_to(EOC - 1);
        check(int_n == 1, "R4 int before end", int_n, 1);
        check(data_oe == 0, "R5 bus before end", data_oe, 0);
        go_to(EOC);
        check(int_n == 0, "R4 int at end", int_n, 0);
        check(data_oe == 1, "R5 bus at end", data_oe, 1);
        check(rdy_pull == 0, "R5 ready released at end", rdy_pull, 0);
        check(mux_sel == 5, "R2 address ignored later", mux_sel, 5);
        go_to(EOC + 2); strobe(0, 1); p = pos;
        go_to(p + 2);
        check(int_n == 0, "R7 int held", int_n, 0);
        check(data_oe == 1, "R10 bus held", data_oe, 1);
        go_to(p + 3);
        check(int_n == 1, "R7 int on read rise", int_n, 1);
        check(data_oe == 0, "R10 bus off", data_oe, 0);
        strobe(1, 1);
        go_to(p + 8);

        // short read, nothing pending; bubble coarse code 0x00B7 has 6 ones
        addr = 3'd3; coarse_therm = 15'h00B7; fine_therm = 15'h7FFF;
        strobe(0, 0); pos = 0;
        go_to(3);
        check(data_oe == 0, "R6 no pending word", data_oe, 0);
        check(mux_sel == 3, "R2 address", mux_sel, 3);
        go_to(4); strobe(1, 1);
        go_to(6);
        check(rdy_pull == 1, "R8 ready still low", rdy_pull, 1);
        go_to(7);
        check(rdy_pull == 0, "R8 ready released on cs rise", rdy_pull, 0);
        go_to(8); addr = 3'd6; strobe(0, 0);
        go_to(11); strobe(1, 1);
        go_to(20);
        check(mux_sel == 3, "R9 busy start ignored", mux_sel, 3);
        go_to(EOC - 1);
        check(int_n == 1, "R9 end time kept", int_n, 1);
        go_to(EOC);
        check(int_n == 0, "R4 int at end", int_n, 0);
        check(data_oe == 0, "R5 no drive after release", data_oe, 0);
        go_to(EOC + 5);

        // pipelined read of 0x6F, new conversion 0 / 1 ones -> 0x01
        exp_q.push_back(8'h6F);
        addr = 3'd1; coarse_therm = 15'h0000; fine_therm = 15'h0001;
        strobe(0, 0); pos = 0;
        go_to(3);
        check(data_oe == 1, "R6 pending word driven", data_oe, 1);
        check(int_n == 0, "R7 int stays low in read", int_n, 0);
        check(mux_sel == 1, "R2 address", mux_sel, 1);
        go_to(5); strobe(1, 1);
        go_to(7);
        check(data_oe == 1, "R10 bus held", data_oe, 1);
        go_to(8);
        check(int_n == 1, "R7 int on strobe rise", int_n, 1);
        check(data_oe == 0, "R10 bus off", data_oe, 0);
        go_to(EOC);
        check(int_n == 0, "R4 int at end", int_n, 0);
        go_to(EOC + 5);

        // pipelined read of 0x01, read released before chip-select
        exp_q.push_back(8'h01);
        addr = 3'd7; coarse_therm = 15'h7FFF; fine_therm = 15'h0000;
        strobe(0, 0); pos = 0;
        go_to(3);
        check(mux_sel == 7, "R2 address", mux_sel, 7);
        go_to(5); strobe(0, 1);
        go_to(8);
        check(int_n == 1, "R7 int on read rise", int_n, 1);
        check(rdy_pull == 1, "R8 ready while cs low", rdy_pull, 1);
        go_to(10); strobe(1, 1);
        go_to(12);
        check(rdy_pull == 1, "R8 ready before cs sync", rdy_pull, 1);
        go_to(13);
        check(rdy_pull == 0, "R8 ready on cs rise", rdy_pull, 0);
        go_to(EOC + 5);

        // last pipelined read returns 15 / 0 ones -> 0xF0
        exp_q.push_back(8'hF0);
        addr = 3'd0;
        strobe(0, 0); pos = 0;
        go_to(5); strobe(1, 1);
        go_to(12);
        check(exp_q.size() == 0, "R6 all words seen", exp_q.size(), 0);
        finish_run();
    end
endmodule